// File: doc/BRIEF.md
# Outstanding Transaction Limiter

This block sits on the address and response channels between a bus master and the interconnect. It caps how many transactions the master may have in flight. It keeps two independent credit counts. Writes are counted from the address handshake to the write response. Reads are counted from the address handshake to the final read beat. When a count reaches the limit `MAX_OUT`, that address channel is closed: VALID is held low toward the bus and READY is held low toward the master. The master keeps its request pending, and the request is forwarded as soon as a completion frees a slot.

Address payloads and response channels pass through combinationally. Back-pressure on every channel follows valid/ready. A transfer takes place only in a cycle where both VALID and READY are high. The limiter never raises a VALID on its own. It only removes one, and only on the address channels. Response channels are never gated, so completions always drain. The two counts are brought out as plain status pins. Transactions are not reordered. ID-ordering rules are left to the master and the slaves.

Top module: `axi_txn_limiter`

## Requirements
- R1: After the active-low reset, `wr_pending` and `rd_pending` are 0.
- R2: A write address handshake on the bus side (`dn_aw_valid && dn_aw_ready`) with no write-response handshake in the same cycle raises `wr_pending` by 1 at the next edge.
- R3: A write-response handshake (`dn_b_valid && up_b_ready`) with no write address handshake in the same cycle lowers `wr_pending` by 1.
- R4: When a write address handshake and a write-response handshake happen in the same cycle, `wr_pending` is unchanged.
- R5: A read address handshake on the bus side raises `rd_pending` by 1 when no final read beat completes in that cycle.
- R6: `rd_pending` is lowered only by a read-data handshake whose last flag (`dn_r_last`) is 1. A beat with the last flag at 0, or a beat that is offered but not accepted, leaves it unchanged.
- R7: While `wr_pending == MAX_OUT`, `dn_aw_valid` and `up_aw_ready` are both 0. A held upstream request is forwarded in the cycle after the count drops below the limit.
- R8: The read channel follows the same limit with its own count. A full write count does not block reads, and while `rd_pending == MAX_OUT`, `dn_ar_valid` and `up_ar_ready` are 0.
- R9: Address, ID, data, response and last fields pass through unchanged. Addresses reach the bus in the order the master presents them, and response VALIDs pass through ungated.
- R10: Neither count ever exceeds `MAX_OUT` (1 to 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_aw_valid | input | 1 | Master write address valid |
| up_aw_ready | output | 1 | Write address ready to master |
| up_aw_addr | input | ADDR_W | Master write address |
| up_aw_id | input | ID_W | Master write ID |
| dn_aw_valid | output | 1 | Write address valid to bus |
| dn_aw_ready | input | 1 | Bus write address ready |
| dn_aw_addr | output | ADDR_W | Write address to bus |
| dn_aw_id | output | ID_W | Write ID to bus |
| dn_b_valid | input | 1 | Bus write response valid |
| dn_b_ready | output | 1 | Write response ready to bus |
| dn_b_id | input | ID_W | Bus write response ID |
| dn_b_resp | input | 2 | Bus write response code |
| up_b_valid | output | 1 | Write response valid to master |
| up_b_ready | input | 1 | Master write response ready |
| up_b_id | output | ID_W | Write response ID to master |
| up_b_resp | output | 2 | Write response code to master |
| up_ar_valid | input | 1 | Master read address valid |
| up_ar_ready | output | 1 | Read address ready to master |
| up_ar_addr | input | ADDR_W | Master read address |
| up_ar_id | input | ID_W | Master read ID |
| dn_ar_valid | output | 1 | Read address valid to bus |
| dn_ar_ready | input | 1 | Bus read address ready |
| dn_ar_addr | output | ADDR_W | Read address to bus |
| dn_ar_id | output | ID_W | Read ID to bus |
| dn_r_valid | input | 1 | Bus read data valid |
| dn_r_ready | output | 1 | Read data ready to bus |
| dn_r_id | input | ID_W | Bus read ID |
| dn_r_data | input | DATA_W | Bus read data |
| dn_r_resp | input | 2 | Bus read response code |
| dn_r_last | input | 1 | Bus final-beat flag |
| up_r_valid | output | 1 | Read data valid to master |
| up_r_ready | input | 1 | Master read data ready |
| up_r_id | output | ID_W | Read ID to master |
| up_r_data | output | DATA_W | Read data to master |
| up_r_resp | output | 2 | Read response code to master |
| up_r_last | output | 1 | Final-beat flag to master |
| wr_pending | output | $clog2(MAX_OUT+1) | Writes awaiting a response |
| rd_pending | output | $clog2(MAX_OUT+1) | Reads awaiting their final beat |

## Verification
The checks assume a legal environment. A write response only arrives while at least one write is pending. A final read beat only arrives while at least one read is pending. Without this, a completion could arrive with nothing to retire, and the counter bounds would not hold. The stimulus meets these assumptions by tracking its own expected counts: it raises a response only after the matching address has been accepted, and it closes every read with exactly one beat that has the last flag set. The bench also holds each upstream VALID, with its payload steady, until the handshake occurs, as the protocol requires.

// File: rtl/olim_pkg.sv
package olim_pkg;
  localparam int RESP_W = 2;
  typedef logic [RESP_W-1:0] olim_resp_t;

  function automatic int cnt_width(input int limit);
    return $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/olim_credit.sv
module olim_credit #(
  parameter int LIMIT = 4,
  parameter int CW    = olim_pkg::cnt_width(LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          give,
  output logic [CW-1:0] cnt,
  output logic          full
);
  localparam logic [CW-1:0] CAP = CW'(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (take && !give)
      cnt <= cnt + 1'b1;
    else if (give && !take)
      cnt <= cnt - 1'b1;
  end

  assign full = (cnt == CAP);
endmodule

// File: rtl/olim_gate.sv
module olim_gate #(
  parameter int PW = 36
) (
  input  logic          block,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [PW-1:0] up_pay,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [PW-1:0] dn_pay,
  output logic          fire
);
  assign dn_valid = up_valid && !block;
  assign up_ready = dn_ready && !block;
  assign dn_pay   = up_pay;
  assign fire     = dn_valid && dn_ready;
endmodule

// File: rtl/olim_resp_tap.sv
module olim_resp_tap #(
  parameter int PW       = 6,
  parameter bit USE_LAST = 1'b0
) (
  input  logic          dn_valid,
  output logic          dn_ready,
  input  logic [PW-1:0] dn_pay,
  input  logic          dn_last,
  output logic          up_valid,
  input  logic          up_ready,
  output logic [PW-1:0] up_pay,
  output logic          done
);
  logic beat;
  assign up_valid = dn_valid;
  assign dn_ready = up_ready;
  assign up_pay   = dn_pay;
  assign beat     = dn_valid && up_ready;

  generate
    if (USE_LAST) begin : g_last
      assign done = beat && dn_last;
    end else begin : g_any
      assign done = beat;
    end
  endgenerate
endmodule

// File: rtl/axi_txn_limiter.sv
module axi_txn_limiter #(
  parameter int MAX_OUT = 4,
  parameter int ADDR_W  = 32,
  parameter int ID_W    = 4,
  parameter int DATA_W  = 32,
  localparam int CW     = olim_pkg::cnt_width(MAX_OUT),
  localparam int RW     = olim_pkg::RESP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_aw_valid,
  output logic              up_aw_ready,
  input  logic [ADDR_W-1:0] up_aw_addr,
  input  logic [ID_W-1:0]   up_aw_id,
  output logic              dn_aw_valid,
  input  logic              dn_aw_ready,
  output logic [ADDR_W-1:0] dn_aw_addr,
  output logic [ID_W-1:0]   dn_aw_id,
  input  logic              dn_b_valid,
  output logic              dn_b_ready,
  input  logic [ID_W-1:0]   dn_b_id,
  input  logic [RW-1:0]     dn_b_resp,
  output logic              up_b_valid,
  input  logic              up_b_ready,
  output logic [ID_W-1:0]   up_b_id,
  output logic [RW-1:0]     up_b_resp,
  input  logic              up_ar_valid,
  output logic              up_ar_ready,
  input  logic [ADDR_W-1:0] up_ar_addr,
  input  logic [ID_W-1:0]   up_ar_id,
  output logic              dn_ar_valid,
  input  logic              dn_ar_ready,
  output logic [ADDR_W-1:0] dn_ar_addr,
  output logic [ID_W-1:0]   dn_ar_id,
  input  logic              dn_r_valid,
  output logic              dn_r_ready,
  input  logic [ID_W-1:0]   dn_r_id,
  input  logic [DATA_W-1:0] dn_r_data,
  input  logic [RW-1:0]     dn_r_resp,
  input  logic              dn_r_last,
  output logic              up_r_valid,
  input  logic              up_r_ready,
  output logic [ID_W-1:0]   up_r_id,
  output logic [DATA_W-1:0] up_r_data,
  output logic [RW-1:0]     up_r_resp,
  output logic              up_r_last,
  output logic [CW-1:0]     wr_pending,
  output logic [CW-1:0]     rd_pending
);
  localparam int APW = ADDR_W + ID_W;
  localparam int BPW = ID_W + RW;
  localparam int RPW = ID_W + DATA_W + RW + 1;

  logic wr_full, rd_full;
  logic aw_fire, ar_fire, b_done, r_done;

  // write address path
  olim_gate #(.PW(APW)) u_aw_gate (
    .block    (wr_full),
    .up_valid (up_aw_valid),
    .up_ready (up_aw_ready),
    .up_pay   ({up_aw_id, up_aw_addr}),
    .dn_valid (dn_aw_valid),
    .dn_ready (dn_aw_ready),
    .dn_pay   ({dn_aw_id, dn_aw_addr}),
    .fire     (aw_fire)
  );

  // read address path
  olim_gate #(.PW(APW)) u_ar_gate (
    .block    (rd_full),
    .up_valid (up_ar_valid),
    .up_ready (up_ar_ready),
    .up_pay   ({up_ar_id, up_ar_addr}),
    .dn_valid (dn_ar_valid),
    .dn_ready (dn_ar_ready),
    .dn_pay   ({dn_ar_id, dn_ar_addr}),
    .fire     (ar_fire)
  );

  // write response: every handshake retires one write
  olim_resp_tap #(.PW(BPW), .USE_LAST(1'b0)) u_b_tap (
    .dn_valid (dn_b_valid),
    .dn_ready (dn_b_ready),
    .dn_pay   ({dn_b_id, dn_b_resp}),
    .dn_last  (1'b1),
    .up_valid (up_b_valid),
    .up_ready (up_b_ready),
    .up_pay   ({up_b_id, up_b_resp}),
    .done     (b_done)
  );

  // read data: only the final beat retires a read
  olim_resp_tap #(.PW(RPW), .USE_LAST(1'b1)) u_r_tap (
    .dn_valid (dn_r_valid),
    .dn_ready (dn_r_ready),
    .dn_pay   ({dn_r_id, dn_r_data, dn_r_resp, dn_r_last}),
    .dn_last  (dn_r_last),
    .up_valid (up_r_valid),
    .up_ready (up_r_ready),
    .up_pay   ({up_r_id, up_r_data, up_r_resp, up_r_last}),
    .done     (r_done)
  );

  olim_credit #(.LIMIT(MAX_OUT), .CW(CW)) u_wr_credit (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (aw_fire),
    .give  (b_done),
    .cnt   (wr_pending),
    .full  (wr_full)
  );

  olim_credit #(.LIMIT(MAX_OUT), .CW(CW)) u_rd_credit (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (ar_fire),
    .give  (r_done),
    .cnt   (rd_pending),
    .full  (rd_full)
  );
endmodule

// File: rtl/axi_txn_limiter_chk.sv
module axi_txn_limiter_chk #(
  parameter int LIMIT = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          up_aw_ready,
  input logic          dn_aw_valid,
  input logic          dn_aw_ready,
  input logic          dn_b_valid,
  input logic          up_b_ready,
  input logic          up_ar_ready,
  input logic          dn_ar_valid,
  input logic          dn_ar_ready,
  input logic          dn_r_valid,
  input logic          up_r_ready,
  input logic          dn_r_last,
  input logic [CW-1:0] wr_pending,
  input logic [CW-1:0] rd_pending
);
  localparam logic [CW-1:0] CAP = CW'(LIMIT);
  logic awf, bf, arf, rf;
  assign awf = dn_aw_valid && dn_aw_ready;
  assign bf  = dn_b_valid && up_b_ready;
  assign arf = dn_ar_valid && dn_ar_ready;
  assign rf  = dn_r_valid && up_r_ready;

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pending <= CAP && rd_pending <= CAP);

  assert_wr_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pending == CAP |-> !dn_aw_valid && !up_aw_ready);

  assert_rd_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pending == CAP |-> !dn_ar_valid && !up_ar_ready);

  assert_wr_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    awf && !bf |=> wr_pending == $past(wr_pending) + 1'b1);

  assert_wr_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bf && !awf |=> wr_pending == $past(wr_pending) - 1'b1);

  assert_wr_same_R4: assert property (@(posedge clk) disable iff (!rst_n)
    awf && bf |=> $stable(wr_pending));

  assert_rd_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arf && !(rf && dn_r_last) |=> rd_pending == $past(rd_pending) + 1'b1);

  assert_rd_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !arf && !(rf && dn_r_last) |=> $stable(rd_pending));
endmodule

bind axi_txn_limiter axi_txn_limiter_chk #(.LIMIT(MAX_OUT), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .up_aw_ready (up_aw_ready),
  .dn_aw_valid (dn_aw_valid),
  .dn_aw_ready (dn_aw_ready),
  .dn_b_valid  (dn_b_valid),
  .up_b_ready  (up_b_ready),
  .up_ar_ready (up_ar_ready),
  .dn_ar_valid (dn_ar_valid),
  .dn_ar_ready (dn_ar_ready),
  .dn_r_valid  (dn_r_valid),
  .up_r_ready  (up_r_ready),
  .dn_r_last   (dn_r_last),
  .wr_pending  (wr_pending),
  .rd_pending  (rd_pending)
);

// File: tb/axi_txn_limiter_test.sv
`timescale 1ns/1ps
module axi_txn_limiter_test;
  localparam int N  = 4;
  localparam int AW = 32;
  localparam int IW = 4;
  localparam int DW = 32;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic up_aw_valid = 0, up_aw_ready, dn_aw_valid, dn_aw_ready = 1;
  logic [AW-1:0] up_aw_addr = 0, dn_aw_addr;
  logic [IW-1:0] up_aw_id = 0, dn_aw_id;
  logic dn_b_valid = 0, dn_b_ready, up_b_valid, up_b_ready = 0;
  logic [IW-1:0] dn_b_id = 0, up_b_id;
  logic [1:0] dn_b_resp = 0, up_b_resp;
  logic up_ar_valid = 0, up_ar_ready, dn_ar_valid, dn_ar_ready = 1;
  logic [AW-1:0] up_ar_addr = 0, dn_ar_addr;
  logic [IW-1:0] up_ar_id = 0, dn_ar_id;
  logic dn_r_valid = 0, dn_r_ready, up_r_valid, up_r_ready = 0;
  logic [IW-1:0] dn_r_id = 0, up_r_id;
  logic [DW-1:0] dn_r_data = 0, up_r_data;
  logic [1:0] dn_r_resp = 0, up_r_resp;
  logic dn_r_last = 0, up_r_last;
  logic [CW-1:0] wr_pending, rd_pending;

  axi_txn_limiter #(.MAX_OUT(N), .ADDR_W(AW), .ID_W(IW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .up_aw_valid(up_aw_valid), .up_aw_ready(up_aw_ready), .up_aw_addr(up_aw_addr), .up_aw_id(up_aw_id),
    .dn_aw_valid(dn_aw_valid), .dn_aw_ready(dn_aw_ready), .dn_aw_addr(dn_aw_addr), .dn_aw_id(dn_aw_id),
    .dn_b_valid(dn_b_valid), .dn_b_ready(dn_b_ready), .dn_b_id(dn_b_id), .dn_b_resp(dn_b_resp),
    .up_b_valid(up_b_valid), .up_b_ready(up_b_ready), .up_b_id(up_b_id), .up_b_resp(up_b_resp),
    .up_ar_valid(up_ar_valid), .up_ar_ready(up_ar_ready), .up_ar_addr(up_ar_addr), .up_ar_id(up_ar_id),
    .dn_ar_valid(dn_ar_valid), .dn_ar_ready(dn_ar_ready), .dn_ar_addr(dn_ar_addr), .dn_ar_id(dn_ar_id),
    .dn_r_valid(dn_r_valid), .dn_r_ready(dn_r_ready), .dn_r_id(dn_r_id), .dn_r_data(dn_r_data),
    .dn_r_resp(dn_r_resp), .dn_r_last(dn_r_last),
    .up_r_valid(up_r_valid), .up_r_ready(up_r_ready), .up_r_id(up_r_id), .up_r_data(up_r_data),
    .up_r_resp(up_r_resp), .up_r_last(up_r_last),
    .wr_pending(wr_pending), .rd_pending(rd_pending)
  );

  int checks = 0;
  int fails  = 0;
  logic [AW+IW-1:0] aw_q[$];
  logic [AW+IW-1:0] ar_q[$];

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic aw_present(input logic [AW-1:0] a, input logic [IW-1:0] id);
    up_aw_valid = 1'b1; up_aw_addr = a; up_aw_id = id;
    aw_q.push_back({id, a});
  endtask

  task automatic ar_present(input logic [AW-1:0] a, input logic [IW-1:0] id);
    up_ar_valid = 1'b1; up_ar_addr = a; up_ar_id = id;
    ar_q.push_back({id, a});
  endtask

  // monitor: samples just before each rising edge
  always @(negedge clk) begin
    #8;
    if (dn_aw_valid && dn_aw_ready) begin
      if (aw_q.size() == 0) check("R9 aw unexpected", 1, 0);
      else check("R9 aw order", {dn_aw_id, dn_aw_addr}, aw_q.pop_front());
    end
    if (dn_ar_valid && dn_ar_ready) begin
      if (ar_q.size() == 0) check("R9 ar unexpected", 1, 0);
      else check("R9 ar order", {dn_ar_id, dn_ar_addr}, ar_q.pop_front());
    end
  end

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 wr", wr_pending, 0);
    check("R1 rd", rd_pending, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill the write budget
    for (int k = 0; k < N; k++) begin
      aw_present(AW'(32'h100 + k * 16), IW'(k));
      tick();
      check("R2 wr inc", wr_pending, k + 1);
    end
    up_aw_valid = 0;

    // request beyond the limit is held
    aw_present(32'h50, 4'd5);
    #1;
    check("R7 up ready", up_aw_ready, 0);
    check("R7 dn valid", dn_aw_valid, 0);
    repeat (3) tick();
    check("R7 hold count", wr_pending, N);

    // reads are not blocked by a full write count
    ar_present(32'h80, 4'd2);
    #1;
    check("R8 ar open", dn_ar_valid, 1);
    tick();
    up_ar_valid = 0;
    check("R5 rd inc", rd_pending, 1);

    // one response frees one slot
    dn_b_valid = 1; dn_b_id = 4'd3; dn_b_resp = 2'd2; up_b_ready = 1;
    #1;
    check("R9 b valid", up_b_valid, 1);
    check("R9 b id", up_b_id, 3);
    check("R9 b resp", up_b_resp, 2);
    tick();
    dn_b_valid = 0; up_b_ready = 0;
    #1;
    check("R3 dec", wr_pending, N - 1);
    check("R7 release", dn_aw_valid, 1);
    check("R7 release id", dn_aw_id, 5);
    tick();
    up_aw_valid = 0;
    check("R7 refill", wr_pending, N);

    // response alone
    dn_b_valid = 1; up_b_ready = 1;
    tick();
    check("R3 dec alone", wr_pending, N - 1);
    // address and response together
    aw_present(32'h60, 4'd6);
    tick();
    up_aw_valid = 0; dn_b_valid = 0; up_b_ready = 0;
    check("R4 same cycle", wr_pending, N - 1);

    // fill the read budget
    for (int k = 1; k < N; k++) begin
      ar_present(AW'(32'h80 + k), IW'(k));
      tick();
    end
    up_ar_valid = 0;
    check("R5 rd full", rd_pending, N);
    ar_present(32'h90, 4'd9);
    #1;
    check("R8 ar blocked", up_ar_ready, 0);
    check("R8 ar dn", dn_ar_valid, 0);

    // non-final beat
    dn_r_valid = 1; dn_r_last = 0; dn_r_data = 32'hCAFE0001; dn_r_id = 4'd1; up_r_ready = 1;
    #1;
    check("R9 r data", up_r_data, 32'hCAFE0001);
    check("R9 r id", up_r_id, 1);
    tick();
    check("R6 no last", rd_pending, N);
    // final beat offered but refused
    dn_r_last = 1; up_r_ready = 0;
    #1;
    check("R6 ready down", dn_r_ready, 0);
    tick();
    check("R6 refused", rd_pending, N);
    // final beat accepted
    up_r_ready = 1;
    #1;
    check("R9 r last", up_r_last, 1);
    tick();
    dn_r_valid = 0; dn_r_last = 0; up_r_ready = 0;
    check("R6 last dec", rd_pending, N - 1);
    check("R8 ar release", dn_ar_valid, 1);
    tick();
    up_ar_valid = 0;
    check("R8 ar refill", rd_pending, N);
    check("R10 wr bound", wr_pending <= N, 1);

    tick();
    check("R9 aw drained", aw_q.size(), 0);
    check("R9 ar drained", ar_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule